// File: doc/BRIEF.md
# Radio Power-Up Initialization Sequencer

This block brings a 2.4 GHz packet transceiver out of reset once the system reset is released. First it raises the regulator enable. After a programmable delay it releases the radio reset, then waits a second delay so that the radio can settle. It then reads the radio's state-machine status register over SPI and stops if the radio does not report idle. Next it polls the radio status byte at a fixed interval until the crystal oscillator reports stable, and gives up after a bounded number of polls. Last, it writes a fixed, ordered list of fifteen register defaults.

The block ends in one of two final states. Either `init_done` rises after the last default write has finished on the bus, or `init_err` carries a code that tells the two failure causes apart. Both hold until the next reset. All delays are counted in pulses of `us_tick`, a one-cycle strobe once per microsecond, so a faster tick or smaller parameters shorten the sequence. The block has no data stream; every pin is plain control or status, and the SPI port runs on its own timing with no handshake.

Top module: `radio_init_seq`

## Requirements
- R1: While `rst_n` is low, `radio_vreg_en`, `radio_rst_n`, `spi_sclk`, `spi_mosi`, `init_done` are 0, `spi_cs_n` is 1 and `init_err` is 0 (no error). A reset asserted in the middle of the sequence returns every output to this state.
- R2: After reset, `radio_vreg_en` rises first. `radio_rst_n` rises only after at least PWR_US `us_tick` pulses have been counted since then, and `radio_rst_n` is never high while `radio_vreg_en` is low.
- R3: The first SPI transaction starts no earlier than RST_US ticks after `radio_rst_n` rises. It is three bytes long: 0x10, 0x33, 0x00. The byte received during the third byte is the radio state. Any nonzero state ends the sequence with `init_err` = 1 and no further transactions.
- R4: After an idle state, the block issues status polls, each a one-byte transaction sending 0x00. Only bit 7 of the received byte (oscillator stable) is looked at. Consecutive polls start at least POLL_US ticks apart. If POLL_MAX polls in a row show bit 7 clear, the sequence ends with `init_err` = 2 and no further transactions.
- R5: On the first poll that shows bit 7 set, the block writes these (address, data) pairs in this order: (0x30,0xF7) (0x36,0x1A) (0x46,0x85) (0x47,0x14) (0x4A,0x3F) (0x4C,0x5A) (0x4F,0x2B) (0x53,0x11) (0x56,0x10) (0x57,0x0E) (0x58,0x03) (0x0C,0x60) (0x0D,0x03) (0x00,0x00) (0x34,0x7F).
- R6: Each default write is a single transaction. An address of 0x3F or lower is sent as two bytes: 0xC0 OR address, then data. A higher address is sent as three bytes: 0x20, address, data.
- R7: `init_done` rises only after `spi_cs_n` has risen at the end of the last default write. Once set, `init_done` or a nonzero `init_err` holds with no further SPI activity until the next reset, and the two are never both set.
- R8: SPI uses mode 0, most significant bit first. `spi_cs_n` stays low for a whole transaction and high between transactions. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sclk` is low. `spi_miso` is sampled on the rising edge of `spi_sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| spi_sclk | output | 1 | SPI serial clock (half the system clock rate) |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the radio |
| spi_miso | input | 1 | SPI data from the radio |
| radio_vreg_en | output | 1 | Radio regulator enable |
| radio_rst_n | output | 1 | Radio reset, active low |
| init_done | output | 1 | Sequence finished successfully |
| init_err | output | 2 | 0 none, 1 radio not idle, 2 oscillator timeout |

## Verification
The sequence is run against a bus-level radio model whose idle-state answer and oscillator-ready poll number come from a vector table. A case that is stable on the first poll is compared with one stable on a later poll, which shows that the poll loop repeats and spaces its polls. A case that turns stable exactly on poll POLL_MAX is set against one that never turns stable, which places the timeout on the exact boundary. Idle answers of 0x01 and 0x80 show that any nonzero bit aborts. In the successful runs the full byte log is compared with the ordered default list, which covers both address encodings, and a reset asserted during the default writes shows that the outputs return to their reset values.

// File: rtl/radio_init_pkg.sv
package radio_init_pkg;
  localparam int BYTE_W         = 8;
  localparam int MAX_XFER_BYTES = 3;
  localparam int NUM_DEFAULTS   = 15;
  localparam int STABLE_BIT     = 7;

  localparam logic [7:0] OP_STATUS      = 8'h00;
  localparam logic [7:0] OP_MEM_RD      = 8'h10;
  localparam logic [7:0] OP_MEM_WR      = 8'h20;
  localparam logic [7:0] OP_REG_WR      = 8'hC0;
  localparam logic [7:0] SHORT_ADDR_TOP = 8'h3F;
  localparam logic [7:0] FSM_STATE_ADDR = 8'h33;

  typedef enum logic [1:0] {
    ERR_NONE        = 2'd0,
    ERR_NOT_IDLE    = 2'd1,
    ERR_OSC_TIMEOUT = 2'd2
  } init_err_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } reg_default_t;

  // Ordered default list; position in the list is the write order.
  function automatic reg_default_t default_at(int unsigned i);
    reg_default_t e;
    case (i)
      0:  e = '{8'h30, 8'hF7};
      1:  e = '{8'h36, 8'h1A};
      2:  e = '{8'h46, 8'h85};
      3:  e = '{8'h47, 8'h14};
      4:  e = '{8'h4A, 8'h3F};
      5:  e = '{8'h4C, 8'h5A};
      6:  e = '{8'h4F, 8'h2B};
      7:  e = '{8'h53, 8'h11};
      8:  e = '{8'h56, 8'h10};
      9:  e = '{8'h57, 8'h0E};
      10: e = '{8'h58, 8'h03};
      11: e = '{8'h0C, 8'h60};
      12: e = '{8'h0D, 8'h03};
      13: e = '{8'h00, 8'h00};
      default: e = '{8'h34, 8'h7F};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/us_delay.sv
module us_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  input  logic             tick,
  output logic             expired
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                   remain <= '0;
    else if (load)                remain <= value;
    else if (tick && remain != 0) remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/default_writer_rom.sv
module default_writer_rom
  import radio_init_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int NB_W  = 2
) (
  input  logic [IDX_W-1:0]                 idx,
  output logic [NB_W-1:0]                  nbytes,
  output logic [MAX_XFER_BYTES*BYTE_W-1:0] frame
);
  reg_default_t ent;

  always_comb begin
    ent = default_at(int'(idx));
    if (ent.addr <= SHORT_ADDR_TOP) begin
      nbytes = NB_W'(2);
      frame  = {OP_REG_WR | ent.addr, ent.data, 8'h00};
    end else begin
      nbytes = NB_W'(3);
      frame  = {OP_MEM_WR, ent.addr, ent.data};
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int MAX_BYTES = 3,
  parameter int BYTE_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [$clog2(MAX_BYTES+1)-1:0]  nbytes,
  input  logic [MAX_BYTES*BYTE_W-1:0]     frame,
  output logic                            busy,
  output logic                            xfer_done,
  output logic [BYTE_W-1:0]               rx_byte,
  output logic                            sclk,
  output logic                            cs_n,
  output logic                            mosi,
  input  logic                            miso
);
  localparam int FRAME_W = MAX_BYTES * BYTE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bitcnt, total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; xfer_done <= 1'b0; sclk <= 1'b0; cs_n <= 1'b1;
      shreg <= '0; rx_byte <= '0; bitcnt <= '0; total <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cs_n   <= 1'b0;
          shreg  <= frame;
          bitcnt <= '0;
          total  <= CNT_W'(nbytes) * CNT_W'(BYTE_W);
        end
      end else if (!sclk) begin
        sclk    <= 1'b1;
        rx_byte <= {rx_byte[BYTE_W-2:0], miso};
      end else begin
        sclk  <= 1'b0;
        shreg <= shreg << 1;
        if (bitcnt == total - 1'b1) begin
          busy      <= 1'b0;
          cs_n      <= 1'b1;
          xfer_done <= 1'b1;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  assign mosi = busy ? shreg[FRAME_W-1] : 1'b0;

  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !sclk && busy) |=> $stable(mosi));
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> (busy || xfer_done));
endmodule

// File: rtl/radio_init_seq.sv
module radio_init_seq
  import radio_init_pkg::*;
#(
  parameter int PWR_US   = 100,
  parameter int RST_US   = 200,
  parameter int POLL_US  = 1,
  parameter int POLL_MAX = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       radio_vreg_en,
  output logic       radio_rst_n,
  output logic       init_done,
  output logic [1:0] init_err
);
  localparam int TMR_MAX = (PWR_US > RST_US) ? ((PWR_US > POLL_US) ? PWR_US : POLL_US)
                                             : ((RST_US > POLL_US) ? RST_US : POLL_US);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);
  localparam int IDX_W   = $clog2(NUM_DEFAULTS);
  localparam int NB_W    = $clog2(MAX_XFER_BYTES + 1);
  localparam int FRAME_W = MAX_XFER_BYTES * BYTE_W;

  typedef enum logic [3:0] {
    ST_BOOT, ST_PWR_WAIT, ST_RST_WAIT, ST_IDLE_WT, ST_POLL, ST_POLL_WT,
    ST_POLL_GAP, ST_WR, ST_WR_WT, ST_DONE, ST_ERR
  } seq_state_e;

  seq_state_e        state;
  logic [POLL_W-1:0] poll_cnt;
  logic [IDX_W-1:0]  wr_idx;

  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              spi_start, spi_busy, spi_done;
  logic [NB_W-1:0]   spi_nb, rom_nb;
  logic [FRAME_W-1:0] spi_frame, rom_frame;
  logic [BYTE_W-1:0] spi_rx;

  us_delay #(.CNT_W(TMR_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(tmr_val),
    .tick(us_tick), .expired(tmr_exp)
  );

  default_writer_rom #(.IDX_W(IDX_W), .NB_W(NB_W)) u_rom (
    .idx(wr_idx), .nbytes(rom_nb), .frame(rom_frame)
  );

  spi_byte_master #(.MAX_BYTES(MAX_XFER_BYTES), .BYTE_W(BYTE_W)) u_spi (
    .clk(clk), .rst_n(rst_n), .start(spi_start), .nbytes(spi_nb),
    .frame(spi_frame), .busy(spi_busy), .xfer_done(spi_done), .rx_byte(spi_rx),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  always_comb begin
    tmr_load  = 1'b0;
    tmr_val   = '0;
    spi_start = 1'b0;
    spi_nb    = rom_nb;
    spi_frame = rom_frame;
    case (state)
      ST_BOOT: begin
        tmr_load = 1'b1; tmr_val = TMR_W'(PWR_US);
      end
      ST_PWR_WAIT: if (tmr_exp) begin
        tmr_load = 1'b1; tmr_val = TMR_W'(RST_US);
      end
      ST_RST_WAIT: if (tmr_exp) begin
        spi_start = 1'b1; spi_nb = NB_W'(3);
        spi_frame = {OP_MEM_RD, FSM_STATE_ADDR, 8'h00};
      end
      ST_POLL: begin
        spi_start = 1'b1; spi_nb = NB_W'(1);
        spi_frame = {OP_STATUS, 16'h0000};
      end
      ST_POLL_WT: if (spi_done && !spi_rx[STABLE_BIT]) begin
        tmr_load = 1'b1; tmr_val = TMR_W'(POLL_US);
      end
      ST_WR: spi_start = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_BOOT; poll_cnt <= '0; wr_idx <= '0;
      radio_vreg_en <= 1'b0; radio_rst_n <= 1'b0;
      init_done <= 1'b0; init_err <= ERR_NONE;
    end else begin
      case (state)
        ST_BOOT: begin
          radio_vreg_en <= 1'b1;
          state <= ST_PWR_WAIT;
        end
        ST_PWR_WAIT: if (tmr_exp) begin
          radio_rst_n <= 1'b1;
          state <= ST_RST_WAIT;
        end
        ST_RST_WAIT: if (tmr_exp) state <= ST_IDLE_WT;
        ST_IDLE_WT: if (spi_done) begin
          if (spi_rx != '0) begin
            init_err <= ERR_NOT_IDLE; state <= ST_ERR;
          end else begin
            state <= ST_POLL;
          end
        end
        ST_POLL: state <= ST_POLL_WT;
        ST_POLL_WT: if (spi_done) begin
          if (spi_rx[STABLE_BIT]) begin
            wr_idx <= '0; state <= ST_WR;
          end else if (poll_cnt == POLL_W'(POLL_MAX - 1)) begin
            poll_cnt <= poll_cnt + 1'b1;
            init_err <= ERR_OSC_TIMEOUT; state <= ST_ERR;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
            state <= ST_POLL_GAP;
          end
        end
        ST_POLL_GAP: if (tmr_exp) state <= ST_POLL;
        ST_WR: state <= ST_WR_WT;
        ST_WR_WT: if (spi_done) begin
          if (wr_idx == IDX_W'(NUM_DEFAULTS - 1)) begin
            init_done <= 1'b1; state <= ST_DONE;
          end else begin
            wr_idx <= wr_idx + 1'b1; state <= ST_WR;
          end
        end
        default: ;
      endcase
    end
  end

  assert_rst_after_vreg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    radio_rst_n |-> radio_vreg_en);
  assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= POLL_W'(POLL_MAX));
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_err != ERR_NONE) |=> $stable(init_err));
  assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_done && init_err != ERR_NONE));
  assert_quiet_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done || init_err != ERR_NONE) |-> !spi_start);
  assert_start_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !spi_busy);
endmodule

// File: tb/tb_radio_init_seq.sv
`timescale 1ns/1ps
module tb_radio_init_seq;
  localparam int PWR_US = 100, RST_US = 200, POLL_US = 1, POLL_MAX = 100;
  localparam int NCASE = 6;
  // {idle state answer, poll number that first reads stable, expected err, expected polls}
  localparam logic [31:0] VEC [0:NCASE-1] = '{
    {8'h00, 8'd1,   8'd0, 8'd1},
    {8'h00, 8'd5,   8'd0, 8'd5},
    {8'h00, 8'd100, 8'd0, 8'd100},
    {8'h00, 8'd200, 8'd2, 8'd100},
    {8'h01, 8'd1,   8'd1, 8'd0},
    {8'h80, 8'd1,   8'd1, 8'd0}
  };

  logic clk = 0, rst_n = 0, us_tick = 0, spi_miso;
  logic spi_sclk, spi_cs_n, spi_mosi, radio_vreg_en, radio_rst_n, init_done;
  logic [1:0] init_err;

  radio_init_seq #(.PWR_US(PWR_US), .RST_US(RST_US), .POLL_US(POLL_US), .POLL_MAX(POLL_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .radio_vreg_en(radio_vreg_en),
    .radio_rst_n(radio_rst_n), .init_done(init_done), .init_err(init_err)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int tick_cnt = 0, tick_vreg = 0, tick_rst = 0;
  logic [7:0] tx_log [0:255];
  int trans_len [0:255];
  int start_tick [0:255];
  int nlog = 0, ntrans = 0, nstart = 0, npoll = 0;
  int bi = 0, by = 0;
  logic [7:0] sh = 0;
  logic [7:0] cfg_idle = 0;
  int cfg_stable = 1;

  initial forever begin
    repeat (3) @(posedge clk);
    #1 us_tick = 1;
    @(posedge clk);
    #1 us_tick = 0;
  end

  always @(posedge clk) if (us_tick) tick_cnt++;
  always @(posedge radio_vreg_en) tick_vreg = tick_cnt;
  always @(posedge radio_rst_n) tick_rst = tick_cnt;
  always @(negedge spi_cs_n) begin
    if (nstart < 256) start_tick[nstart] = tick_cnt;
    nstart++;
  end

  // Radio model: sample MOSI on SCLK rise, log each transaction at CS rise.
  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      if (ntrans < 256) trans_len[ntrans] = by;
      if (by == 1) npoll++;
      ntrans++;
      bi = 0; by = 0;
    end else begin
      sh = {sh[6:0], spi_mosi};
      if (bi == 7) begin
        if (nlog < 256) tx_log[nlog] = sh;
        nlog++; bi = 0; by++;
      end else bi++;
    end
  end

  function automatic logic [7:0] resp_byte(int b);
    if (b == 0) return (npoll + 1 >= cfg_stable) ? 8'h80 : 8'h7F;
    else if (b == 2) return cfg_idle;
    else return 8'h00;
  endfunction
  assign spi_miso = spi_cs_n ? 1'b0 : resp_byte(by)[7 - bi];

  function automatic logic [15:0] exp_default(int i);
    case (i)
      0: return 16'h30F7;  1: return 16'h361A;  2: return 16'h4685;  3: return 16'h4714;
      4: return 16'h4A3F;  5: return 16'h4C5A;  6: return 16'h4F2B;  7: return 16'h5311;
      8: return 16'h5610;  9: return 16'h570E; 10: return 16'h5803; 11: return 16'h0C60;
      12: return 16'h0D03; 13: return 16'h0000; default: return 16'h347F;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (4) @(negedge clk);
    nlog = 0; ntrans = 0; nstart = 0; npoll = 0; bi = 0; by = 0;
    chk(radio_vreg_en == 0 && radio_rst_n == 0, "R1", "power pins in reset", {radio_vreg_en, radio_rst_n}, 0);
    chk(spi_cs_n == 1 && spi_sclk == 0 && spi_mosi == 0, "R1", "spi pins in reset", {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
    chk(init_done == 0 && init_err == 0, "R1", "status in reset", {init_done, init_err}, 0);
  endtask

  task automatic run_case(input int ci);
    logic [7:0] idle, stab, eerr, epol;
    int cyc, pos, ln, k0, snap;
    bit ok;
    {idle, stab, eerr, epol} = VEC[ci];
    cfg_idle = idle; cfg_stable = int'(stab);
    do_reset();
    rst_n = 1;
    cyc = 0;
    while (!(init_done || init_err != 0) && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(cyc < 20000, "R7", $sformatf("case %0d finished", ci), cyc, 20000);
    chk(int'(init_err) == int'(eerr), "R7", $sformatf("case %0d error code", ci), init_err, eerr);
    chk(init_done == (eerr == 0), "R7", $sformatf("case %0d done flag", ci), init_done, eerr == 0);
    chk(tick_rst - tick_vreg >= PWR_US, "R2", "ticks vreg to reset release", tick_rst - tick_vreg, PWR_US);
    chk(start_tick[0] - tick_rst >= RST_US, "R3", "ticks reset release to first read", start_tick[0] - tick_rst, RST_US);
    chk(trans_len[0] == 3 && tx_log[0] == 8'h10 && tx_log[1] == 8'h33 && tx_log[2] == 8'h00,
        "R3", "idle read bytes", {tx_log[0], tx_log[1], tx_log[2]}, 24'h103300);
    chk(npoll == int'(epol), "R4", $sformatf("case %0d poll count", ci), npoll, epol);
    ok = 1;
    for (int i = 1; i <= npoll; i++) begin
      if (trans_len[i] != 1 || tx_log[2 + i] != 8'h00) ok = 0;
      if (i > 1 && start_tick[i] - start_tick[i-1] < POLL_US) ok = 0;
    end
    chk(ok, "R4", "poll framing and spacing", ok, 1);
    if (eerr == 0) begin
      pos = 3 + npoll; ok = 1; k0 = 1 + npoll;
      for (int k = 0; k < 15; k++) begin
        logic [15:0] e;
        e = exp_default(k);
        ln = (e[15:8] <= 8'h3F) ? 2 : 3;
        if (trans_len[k0 + k] != ln) ok = 0;
        if (ln == 2) begin
          if (tx_log[pos] != (8'hC0 | e[15:8]) || tx_log[pos+1] != e[7:0]) ok = 0;
        end else begin
          if (tx_log[pos] != 8'h20 || tx_log[pos+1] != e[15:8] || tx_log[pos+2] != e[7:0]) ok = 0;
        end
        pos += ln;
      end
      chk(ok, "R5", $sformatf("case %0d default order", ci), ok, 1);
      chk(ok && ntrans == k0 + 15 && nlog == pos, "R6", "write encoding and count", ntrans, k0 + 15);
    end else begin
      chk(ntrans == 1 + npoll, "R3", "no transactions after error", ntrans, 1 + npoll);
    end
    snap = ntrans;
    repeat (200) @(negedge clk);
    chk(ntrans == snap && spi_cs_n == 1, "R7", "bus quiet after finish", ntrans, snap);
    chk(int'(init_err) == int'(eerr) && init_done == (eerr == 0), "R7", "final state held",
        {init_done, init_err}, {eerr == 0, eerr[1:0]});
    chk(radio_vreg_en && radio_rst_n, "R2", "radio powered after sequence", {radio_vreg_en, radio_rst_n}, 3);
  endtask

  initial begin
    int cyc;
    for (int c = 0; c < NCASE; c++) run_case(c);
    // Directed: reset during the default writes.
    cfg_idle = 0; cfg_stable = 1;
    do_reset();
    rst_n = 1;
    cyc = 0;
    while (ntrans < 6 && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(ntrans >= 6, "R5", "reached default writes", ntrans, 6);
    repeat (7) @(negedge clk);
    do_reset();
    chk(init_done == 0, "R1", "done cleared by mid-sequence reset", init_done, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL R7 watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule